// File: doc/BRIEF.md
# Register Bounds Check Trap Unit

This block performs the range test for an array-bounds check instruction. On a start strobe it takes a signed checked value and a signed upper bound, both 32 bits wide, and classifies the value into one of three outcomes: in range, negative, or above the bound. Either out-of-range outcome raises a trap request. The request comes with a fixed exception vector number, the return address to save, and the new value of the negative (N) condition flag.

The negative test has priority. A negative value traps with N set, whatever the bound is. A non-negative value that is greater than the bound traps with N cleared. A value in range raises no trap, and N takes the flag value presented at the start. The block also extracts the two register index fields from the instruction word, so that the register file can supply the checked value and the bound. Exception stacking and vector fetch are handled elsewhere.

Top module: `bchk_trap_unit`

## Requirements
- R1: `chk_idx_o` equals instruction bits 11:9 (the checked register) and `bnd_idx_o` equals instruction bits 2:0 (the bound register), combinationally.
- R2: When `start_i` is high and the checked value has bit 31 set, `trap_req_o` is high and `n_flag_o` is 1 in the next cycle, whatever the bound.
- R3: When `start_i` is high and a non-negative checked value is greater than the bound, `trap_req_o` is high and `n_flag_o` is 0 in the next cycle.
- R4: The bound comparison is signed two's complement. A value of 0 against a bound of -1 traps, and a value equal to the bound does not trap.
- R5: When `start_i` is high and the value is neither negative nor above the bound, `trap_req_o` stays low next cycle and `n_flag_o` takes the `n_flag_i` value seen at the start.
- R6: In every cycle where `trap_req_o` is high, `trap_vec_o` equals 6.
- R7: In every cycle where `trap_req_o` is high, `ret_pc_o` equals the `pc_i` sampled at the start minus 2, modulo 2^32.
- R8: `trap_req_o` is high only in the cycle right after a start, so each start gives at most one single-cycle pulse.
- R9: In a cycle after a clock edge with no start, `n_flag_o`, `trap_vec_o` and `ret_pc_o` keep their values; `n_flag_i` and `pc_i` have no effect.
- R10: While reset is active, `trap_req_o`, `n_flag_o`, `trap_vec_o` and `ret_pc_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle per check |
| instr_i | input | 16 | Instruction word carrying the register fields |
| chk_val_i | input | 32 | Signed value under test |
| bound_i | input | 32 | Signed upper bound |
| pc_i | input | 32 | Program counter sampled at start |
| n_flag_i | input | 1 | Current N flag |
| chk_idx_o | output | 3 | Index of the checked register |
| bnd_idx_o | output | 3 | Index of the bound register |
| trap_req_o | output | 1 | Single-cycle trap request |
| trap_vec_o | output | 8 | Exception vector number |
| ret_pc_o | output | 32 | Return address to save |
| n_flag_o | output | 1 | Updated N flag |

## Verification
The value/bound pairs are chosen to separate the three outcomes: in range, equal to the bound, above a positive bound, and negative. Further pairs tell a signed compare from an unsigned one: zero against a negative bound, the largest positive value equal to its bound, and the most negative value. A negative value whose bound it also exceeds shows that the negative test wins and sets N. Back-to-back starts, idle cycles with changing flag and PC inputs, and a PC of zero check the pulse shape, the hold behaviour and the wrap of the return address.

// File: rtl/bchk_pkg.sv
package bchk_pkg;
  typedef enum logic [1:0] {
    CHK_PASS = 2'd0,
    CHK_NEG  = 2'd1,
    CHK_OVER = 2'd2
  } chk_cause_e;
endpackage

// File: rtl/bchk_rst_sync.sv
module bchk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bchk_field_decode.sv
module bchk_field_decode #(
  parameter int INSTR_W = 16,
  parameter int IDX_W   = 3,
  parameter int CHK_LSB = 9,
  parameter int BND_LSB = 0
) (
  input  logic [INSTR_W-1:0] instr,
  output logic [IDX_W-1:0]   chk_idx,
  output logic [IDX_W-1:0]   bnd_idx
);
  assign chk_idx = instr[CHK_LSB +: IDX_W];
  assign bnd_idx = instr[BND_LSB +: IDX_W];
endmodule

// File: rtl/bchk_classify.sv
module bchk_classify
  import bchk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] bound,
  output chk_cause_e        cause
);
  logic above;

  assign above = $signed(value) > $signed(bound);

  // Negative test first: it takes priority over the bound test
  always_comb begin
    if (value[DATA_W-1]) cause = CHK_NEG;
    else if (above)      cause = CHK_OVER;
    else                 cause = CHK_PASS;
  end
endmodule

// File: rtl/bchk_trap_unit.sv
module bchk_trap_unit
  import bchk_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int INSTR_W  = 16,
  parameter int IDX_W    = 3,
  parameter int CHK_LSB  = 9,
  parameter int BND_LSB  = 0,
  parameter int VEC_W    = 8,
  parameter int TRAP_VEC = 6,
  parameter int PC_ADJ   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  chk_val_i,
  input  logic [DATA_W-1:0]  bound_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic               n_flag_i,
  output logic [IDX_W-1:0]   chk_idx_o,
  output logic [IDX_W-1:0]   bnd_idx_o,
  output logic               trap_req_o,
  output logic [VEC_W-1:0]   trap_vec_o,
  output logic [ADDR_W-1:0]  ret_pc_o,
  output logic               n_flag_o
);
  localparam logic [VEC_W-1:0]  VEC_VAL = VEC_W'(TRAP_VEC);
  localparam logic [ADDR_W-1:0] ADJ_VAL = ADDR_W'(PC_ADJ);

  logic       rst_sync_n;
  chk_cause_e cause;

  logic              trap_d, trap_q;
  logic              n_d, n_q;
  logic [VEC_W-1:0]  vec_d, vec_q;
  logic [ADDR_W-1:0] pc_d, pc_q;
  logic              upd_en;

  bchk_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bchk_field_decode #(
    .INSTR_W(INSTR_W), .IDX_W(IDX_W), .CHK_LSB(CHK_LSB), .BND_LSB(BND_LSB)
  ) u_dec (
    .instr(instr_i), .chk_idx(chk_idx_o), .bnd_idx(bnd_idx_o)
  );

  bchk_classify #(.DATA_W(DATA_W)) u_cls (
    .value(chk_val_i), .bound(bound_i), .cause(cause)
  );

  // Next-state logic
  always_comb begin
    upd_en = start_i;
    trap_d = start_i && (cause != CHK_PASS);
    n_d    = n_q;
    vec_d  = vec_q;
    pc_d   = pc_q;
    if (start_i) begin
      unique case (cause)
        CHK_NEG:  n_d = 1'b1;
        CHK_OVER: n_d = 1'b0;
        default:  n_d = n_flag_i;
      endcase
      if (trap_d) begin
        vec_d = VEC_VAL;
        pc_d  = pc_i - ADJ_VAL;
      end
    end
  end

  // Pulse register: updated every cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) trap_q <= 1'b0;
    else             trap_q <= trap_d;
  end

  // Result registers: clock enable on start
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      n_q   <= 1'b0;
      vec_q <= '0;
      pc_q  <= '0;
    end else if (upd_en) begin
      n_q   <= n_d;
      vec_q <= vec_d;
      pc_q  <= pc_d;
    end
  end

  assign trap_req_o = trap_q;
  assign trap_vec_o = vec_q;
  assign ret_pc_o   = pc_q;
  assign n_flag_o   = n_q;

  // Assertions
  assert_neg_trap_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && chk_val_i[DATA_W-1]) |=> (trap_req_o && n_flag_o));

  assert_over_trap_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !chk_val_i[DATA_W-1] && ($signed(chk_val_i) > $signed(bound_i)))
      |=> (trap_req_o && !n_flag_o));

  assert_pass_keep_n_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !chk_val_i[DATA_W-1] && !($signed(chk_val_i) > $signed(bound_i)))
      |=> (!trap_req_o && (n_flag_o == $past(n_flag_i))));

  assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_req_o |-> (trap_vec_o == VEC_VAL));

  assert_ret_pc_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && chk_val_i[DATA_W-1]) |=> (ret_pc_o == $past(pc_i) - ADJ_VAL));

  assert_pulse_only_after_start_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !start_i |=> !trap_req_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !start_i |=> ($stable(n_flag_o) && $stable(ret_pc_o) && $stable(trap_vec_o)));

  always_comb begin
    if (!rst_sync_n) begin
      assert_reset_R10: assert (!trap_q && !n_q && (vec_q == '0) && (pc_q == '0));
    end
  end
endmodule

// File: tb/tb_bchk_trap_unit.sv
module tb_bchk_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] instr_i;
  logic [31:0] chk_val_i, bound_i, pc_i;
  logic        n_flag_i;
  logic [2:0]  chk_idx_o, bnd_idx_o;
  logic        trap_req_o;
  logic [7:0]  trap_vec_o;
  logic [31:0] ret_pc_o;
  logic        n_flag_o;

  integer n_checks = 0;
  integer n_fail   = 0;

  // Reference model state
  logic        m_trap, m_n;
  logic [7:0]  m_vec;
  logic [31:0] m_pc;

  always #4 clk = ~clk;

  bchk_trap_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
    .chk_val_i(chk_val_i), .bound_i(bound_i), .pc_i(pc_i), .n_flag_i(n_flag_i),
    .chk_idx_o(chk_idx_o), .bnd_idx_o(bnd_idx_o), .trap_req_o(trap_req_o),
    .trap_vec_o(trap_vec_o), .ret_pc_o(ret_pc_o), .n_flag_o(n_flag_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag,  "trap_req", {31'b0, trap_req_o}, {31'b0, m_trap});
    check(tag,  "n_flag",   {31'b0, n_flag_o},   {31'b0, m_n});
    check("R6", "trap_vec", {24'b0, trap_vec_o}, {24'b0, m_vec});
    check("R7", "ret_pc",   ret_pc_o, m_pc);
    check("R1", "chk_idx",  {29'b0, chk_idx_o},  {29'b0, instr_i[11:9]});
    check("R1", "bnd_idx",  {29'b0, bnd_idx_o},  {29'b0, instr_i[2:0]});
  endtask

  // One clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cycle(input logic st, input logic [31:0] v, input logic [31:0] b,
                       input logic [31:0] p, input logic ni, input logic [15:0] ins,
                       input string tag);
    start_i = st; chk_val_i = v; bound_i = b; pc_i = p; n_flag_i = ni; instr_i = ins;
    @(posedge clk);
    if (st) begin
      if ($signed(v) < 0) begin
        m_trap = 1'b1; m_n = 1'b1; m_vec = 8'd6; m_pc = p - 32'd2;
      end else if ($signed(v) > $signed(b)) begin
        m_trap = 1'b1; m_n = 1'b0; m_vec = 8'd6; m_pc = p - 32'd2;
      end else begin
        m_trap = 1'b0; m_n = ni;
      end
    end else begin
      m_trap = 1'b0;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; instr_i = 16'h0; chk_val_i = '0; bound_i = '0;
    pc_i = '0; n_flag_i = 1'b0;
    m_trap = 1'b0; m_n = 1'b0; m_vec = '0; m_pc = '0;
    repeat (3) @(negedge clk);
    compare_all("R10");
    rst_n = 1'b1;
    repeat (3) cycle(1'b0, 0, 0, 32'h100, 1'b1, 16'h4181, "R10");

    cycle(1'b1, 32'd5,        32'd10,       32'h0000_1004, 1'b1, 16'h4380, "R5");
    cycle(1'b1, 32'hFFFF_FFFF, 32'd100,     32'h0000_2000, 1'b0, 16'h4581, "R2");
    cycle(1'b1, 32'd20,       32'd10,       32'h0000_3002, 1'b1, 16'h4782, "R3");
    cycle(1'b1, 32'd10,       32'd10,       32'h0000_3010, 1'b0, 16'h4983, "R4");
    cycle(1'b1, 32'd0,        32'hFFFF_FFFF, 32'h0000_4000, 1'b1, 16'h4B84, "R4");
    cycle(1'b1, 32'hFFFF_FFFB, 32'hFFFF_FFF6, 32'h0000_5000, 1'b0, 16'h4D85, "R2");
    cycle(1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0000_6000, 1'b1, 16'h4F86, "R4");
    cycle(1'b1, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_7000, 1'b0, 16'h4187, "R2");
    cycle(1'b1, 32'd1,        32'd0,        32'h0000_0000, 1'b1, 16'h4380, "R7");
    cycle(1'b0, 32'hFFFF_FFFF, 32'd0,       32'h1234_5678, 1'b1, 16'h4581, "R8");
    cycle(1'b0, 32'd3,        32'd0,        32'h0000_9999, 1'b0, 16'h4782, "R9");
    cycle(1'b1, 32'd3,        32'd7,        32'h0000_A000, 1'b0, 16'h4983, "R5");
    cycle(1'b0, 32'd3,        32'd7,        32'h0000_B000, 1'b1, 16'h4B84, "R9");
    cycle(1'b1, 32'd50,       32'd7,        32'h0000_C000, 1'b1, 16'h4D85, "R3");
    cycle(1'b1, 32'h8000_0001, 32'd7,       32'h0000_D000, 1'b0, 16'h4F86, "R2");
    cycle(1'b1, 32'd50,       32'd7,        32'h0000_E000, 1'b1, 16'h4187, "R3");
    for (int i = 0; i < 4; i++)
      cycle(1'b0, 32'(i), 32'd0, 32'(i * 16), i[0], 16'(i * 16'h0203), "R8");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule